// File: doc/BRIEF.md
# Video Memory Access Port with Address Remapping

This block is the processor-side window into a 64K-word video memory. Software programs a word address through two byte registers and selects its access behaviour through a control register. It then moves data through byte-wide write and read ports. Each data access reaches the memory through a word-wide interface with a byte enable per half. Before an access leaves the block, its address can be bit-rotated so that graphics data stored row by row lands in the layout the tile fetcher expects.

The stored address steps after every access to the selected byte lane. The step is 1, 32 or 128 words and wraps at the top of the address space. Writes reach memory in the same cycle. Reads are served from a one-word buffer that is refilled from memory only in the cycle that also steps the address. This is why the first read after an address change returns whatever the buffer held before. The memory itself sits outside the block.

Top module: `vram_port`

## Requirements
- R1: After reset the stored address, the control register and the read buffer are all zero. The read port therefore returns 0x00 for both bytes and `mem_addr` is 0x0000.
- R2: `cpu_sel` encodes the target register: 0 control, 1 address bits 7:0, 2 address bits 15:8, 3 low data byte, 4 high data byte. With remap mode 00, `mem_addr` equals the stored word address.
- R3: Control bit 7 chooses the stepping lane. At 0 the address steps after a low-byte data write or read (`cpu_sel`=3). At 1 it steps after a high-byte access (`cpu_sel`=4).
- R4: Control bits 1:0 set the step size in words: 00 gives 1, 01 gives 32, and 10 or 11 gives 128.
- R5: Control bits 3:2 choose the translation applied to `mem_addr`, where ADDR_W=16 and the letters name address bits from bit 15 down. 01 maps aaaaaaaaBBBccccc to aaaaaaaacccccBBB. 10 maps aaaaaaaBBBcccccc to aaaaaaaccccccBBB. 11 maps aaaaaaBBBccccccc to aaaaaacccccccBBB.
- R6: Translation affects only the outgoing address. In mode 01 with the stored address at 0x0003, a stepping access goes to word 0x0018 and the stored address becomes 0x0004.
- R7: A data write drives `mem_we` in the access cycle with exactly one byte enable set, whether or not the access steps. `mem_be[0]` marks the low byte, `mem_be[1]` marks the high byte, and the written byte appears on both halves of `mem_wdata`.
- R8: A data read returns the selected byte of the buffer as it stood before the access. A stepping read raises `mem_re`, loads `mem_rdata` at the translated address into the buffer, and then steps the address.
- R9: A data read on the non-stepping lane leaves both the buffer and the address unchanged.
- R10: The address wraps modulo 65536 when it steps.
- R11: When `cpu_wr` and `cpu_rd` are both high, only the write is performed and `mem_re` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_wr | input | 1 | Register write strobe |
| cpu_rd | input | 1 | Data read strobe |
| cpu_sel | input | 3 | Register select |
| cpu_wdata | input | 8 | Write byte |
| cpu_rdata | output | 8 | Read byte taken from the buffer |
| mem_addr | output | 16 | Translated word address |
| mem_we | output | 1 | Memory write strobe |
| mem_be | output | 2 | Byte enables, bit 0 low byte |
| mem_wdata | output | 16 | Write data, byte replicated |
| mem_re | output | 1 | Buffer refill strobe |
| mem_rdata | input | 16 | Memory word at `mem_addr` |

## Verification
The bench builds the block with its defaults: a 16-bit address and steps of 32 and 128. At these values the three rotation modes can be checked against their full bit patterns, and stepping by 1 and by 128 from near the top of memory reaches the wrap point. The bench memory returns words combinationally. This lets the stale first read and the refill-before-step order be checked against a behavioural model on every data access, while translated addresses are compared on every clock.

// File: rtl/vram_port_pkg.sv
`timescale 1ns/1ps
package vram_port_pkg;
   typedef enum logic [2:0] {
      SEL_CTRL    = 3'd0,
      SEL_ADDR_LO = 3'd1,
      SEL_ADDR_HI = 3'd2,
      SEL_DATA_LO = 3'd3,
      SEL_DATA_HI = 3'd4
   } port_sel_e;

   typedef struct packed {
      logic       hi_trigger;
      logic [1:0] remap;
      logic [1:0] step;
   } port_ctrl_t;
endpackage

// File: rtl/vram_remap.sv
`timescale 1ns/1ps
module vram_remap #(
   parameter int ADDR_W = 16
) (
   input  logic [ADDR_W-1:0] addr_in,
   input  logic [1:0]        mode,
   output logic [ADDR_W-1:0] addr_out
);
   localparam int NMODES = 4;

   logic [ADDR_W-1:0] cand [NMODES];

   assign cand[0] = addr_in;

   for (genvar m = 1; m < NMODES; m++) begin : g_mode
      localparam int CW = 4 + m;
      localparam int LW = CW + 3;
      assign cand[m] = {addr_in[ADDR_W-1:LW], addr_in[CW-1:0], addr_in[LW-1:CW]};
   end

   assign addr_out = cand[mode];
endmodule

// File: rtl/vram_addr_ctr.sv
`timescale 1ns/1ps
module vram_addr_ctr #(
   parameter int ADDR_W   = 16,
   parameter int STEP_MID = 32,
   parameter int STEP_BIG = 128
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_lo,
   input  logic              load_hi,
   input  logic [7:0]        byte_in,
   input  logic              step_en,
   input  logic [1:0]        step_sel,
   output logic [ADDR_W-1:0] addr_q
);
   localparam int HI_W = ADDR_W - 8;

   logic [ADDR_W-1:0] step_amt;

   always_comb begin
      case (step_sel)
         2'b00:   step_amt = ADDR_W'(1);
         2'b01:   step_amt = ADDR_W'(STEP_MID);
         default: step_amt = ADDR_W'(STEP_BIG);
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         addr_q <= '0;
      else if (load_lo)
         addr_q[7:0] <= byte_in;
      else if (load_hi)
         addr_q[ADDR_W-1:8] <= byte_in[HI_W-1:0];
      else if (step_en)
         addr_q <= addr_q + step_amt;
   end
endmodule

// File: rtl/vram_prefetch.sv
`timescale 1ns/1ps
module vram_prefetch #(
   parameter int WORD_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fill,
   input  logic [WORD_W-1:0] fill_data,
   input  logic              pick_hi,
   output logic [WORD_W-1:0] buf_q,
   output logic [7:0]        byte_out
);
   always_ff @(posedge clk) begin
      if (!rst_n)
         buf_q <= '0;
      else if (fill)
         buf_q <= fill_data;
   end

   assign byte_out = pick_hi ? buf_q[WORD_W-1:8] : buf_q[7:0];
endmodule

// File: rtl/vram_port.sv
`timescale 1ns/1ps
module vram_port #(
   parameter int ADDR_W   = 16,
   parameter int STEP_MID = 32,
   parameter int STEP_BIG = 128
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_wr,
   input  logic              cpu_rd,
   input  logic [2:0]        cpu_sel,
   input  logic [7:0]        cpu_wdata,
   output logic [7:0]        cpu_rdata,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_we,
   output logic [1:0]        mem_be,
   output logic [15:0]       mem_wdata,
   output logic              mem_re,
   input  logic [15:0]       mem_rdata
);
   import vram_port_pkg::*;

   localparam int WORD_W = 16;

   if (ADDR_W < 11 || ADDR_W > 16) begin : g_bad_addr_w
      $error("vram_port: ADDR_W must lie in 11..16");
   end
   if (STEP_MID < 1 || STEP_BIG < 1) begin : g_bad_step
      $error("vram_port: step sizes must be positive");
   end

   port_ctrl_t        ctrl_q;
   logic [ADDR_W-1:0] addr_q;
   logic [WORD_W-1:0] buf_q;

   port_sel_e sel;
   assign sel = port_sel_e'(cpu_sel);

   logic wr_lo, wr_hi, rd_lo, rd_hi, step_now;

   assign wr_lo    = cpu_wr && (sel == SEL_DATA_LO);
   assign wr_hi    = cpu_wr && (sel == SEL_DATA_HI);
   assign rd_lo    = cpu_rd && !cpu_wr && (sel == SEL_DATA_LO);
   assign rd_hi    = cpu_rd && !cpu_wr && (sel == SEL_DATA_HI);
   assign step_now = ctrl_q.hi_trigger ? (wr_hi || rd_hi) : (wr_lo || rd_lo);

   always_ff @(posedge clk) begin
      if (!rst_n)
         ctrl_q <= '0;
      else if (cpu_wr && sel == SEL_CTRL)
         ctrl_q <= '{hi_trigger: cpu_wdata[7], remap: cpu_wdata[3:2], step: cpu_wdata[1:0]};
   end

   vram_addr_ctr #(
      .ADDR_W  (ADDR_W),
      .STEP_MID(STEP_MID),
      .STEP_BIG(STEP_BIG)
   ) u_addr (
      .clk     (clk),
      .rst_n   (rst_n),
      .load_lo (cpu_wr && sel == SEL_ADDR_LO),
      .load_hi (cpu_wr && sel == SEL_ADDR_HI),
      .byte_in (cpu_wdata),
      .step_en (step_now),
      .step_sel(ctrl_q.step),
      .addr_q  (addr_q)
   );

   vram_remap #(.ADDR_W(ADDR_W)) u_remap (
      .addr_in (addr_q),
      .mode    (ctrl_q.remap),
      .addr_out(mem_addr)
   );

   vram_prefetch #(.WORD_W(WORD_W)) u_buf (
      .clk      (clk),
      .rst_n    (rst_n),
      .fill     (mem_re),
      .fill_data(mem_rdata),
      .pick_hi  (sel == SEL_DATA_HI),
      .buf_q    (buf_q),
      .byte_out (cpu_rdata)
   );

   assign mem_re    = step_now && (rd_lo || rd_hi);
   assign mem_we    = wr_lo || wr_hi;
   assign mem_be    = {wr_hi, wr_lo};
   assign mem_wdata = {cpu_wdata, cpu_wdata};
endmodule

// File: rtl/vram_port_chk.sv
`timescale 1ns/1ps
module vram_port_chk #(
   parameter int ADDR_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              mem_we,
   input logic [1:0]        mem_be,
   input logic              mem_re,
   input logic [15:0]       mem_rdata,
   input logic [ADDR_W-1:0] mem_addr,
   input logic [ADDR_W-1:0] addr_q,
   input logic [15:0]       buf_q,
   input logic [1:0]        remap_mode,
   input logic [1:0]        step_sel,
   input logic              hi_trig
);
   // R7
   one_lane_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> $countones(mem_be) == 1);

   // R11
   write_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_re |-> !mem_we);

   // R9
   buffer_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_re |=> $stable(buf_q));

   // R8
   buffer_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_re |=> buf_q == $past(mem_rdata));

   // R2
   plain_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
      remap_mode == 2'b00 |-> mem_addr == addr_q);

   // R3
   low_lane_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_we && mem_be == 2'b01 && !hi_trig && step_sel == 2'b00)
      |=> addr_q == $past(addr_q) + ADDR_W'(1));
endmodule

bind vram_port vram_port_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .mem_we    (mem_we),
   .mem_be    (mem_be),
   .mem_re    (mem_re),
   .mem_rdata (mem_rdata),
   .mem_addr  (mem_addr),
   .addr_q    (addr_q),
   .buf_q     (buf_q),
   .remap_mode(ctrl_q.remap),
   .step_sel  (ctrl_q.step),
   .hi_trig   (ctrl_q.hi_trigger)
);

// File: tb/vram_port_test.sv
`timescale 1ns/1ps
module vram_port_test;
   localparam int MEMW = 4096;

   logic        clk = 0;
   logic        rst_n = 0;
   logic        cpu_wr = 0, cpu_rd = 0;
   logic [2:0]  cpu_sel = 0;
   logic [7:0]  cpu_wdata = 0;
   logic [7:0]  cpu_rdata;
   logic [15:0] mem_addr, mem_wdata, mem_rdata;
   logic        mem_we, mem_re;
   logic [1:0]  mem_be;

   int total = 0, bad = 0;
   bit running = 0;

   logic [15:0] vmem [MEMW];
   logic [15:0] m_mem [MEMW];
   int m_addr = 0, m_ctrl = 0, m_buf = 0;

   always #2 clk = ~clk;

   vram_port uut (
      .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_rd(cpu_rd),
      .cpu_sel(cpu_sel), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
      .mem_addr(mem_addr), .mem_we(mem_we), .mem_be(mem_be),
      .mem_wdata(mem_wdata), .mem_re(mem_re), .mem_rdata(mem_rdata)
   );

   assign mem_rdata = vmem[mem_addr[11:0]];

   always @(posedge clk) begin
      if (mem_we) begin
         if (mem_be[0]) vmem[mem_addr[11:0]][7:0]  <= mem_wdata[7:0];
         if (mem_be[1]) vmem[mem_addr[11:0]][15:8] <= mem_wdata[15:8];
      end
   end

   function automatic int xlate(int a, int mode);
      int cw, span, low;
      if (mode == 0) return a;
      cw   = 4 + mode;
      span = 1 << (cw + 3);
      low  = a % span;
      return (a - low) + ((low % (1 << cw)) * 8) + (low / (1 << cw));
   endfunction

   function automatic int step_of(int c);
      case (c & 3)
         0: return 1;
         1: return 32;
         default: return 128;
      endcase
   endfunction

   task automatic chk(bit ok, string req, int act, int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   // every clock: translated address against the model (R2, R5)
   always @(negedge clk) begin
      if (running) begin
         int e;
         e = xlate(m_addr, (m_ctrl >> 2) & 3);
         chk(mem_addr == e[15:0], "R5 clock", mem_addr, e);
      end
   end

   task automatic op(bit wr, bit rd, int sel, int d);
      int t, w;
      bit hi, acc, inc;
      @(negedge clk);
      cpu_wr = wr; cpu_rd = rd; cpu_sel = sel[2:0]; cpu_wdata = d[7:0];
      #1;
      t   = xlate(m_addr, (m_ctrl >> 2) & 3);
      hi  = (sel == 4);
      acc = (wr || rd) && (sel == 3 || sel == 4);
      inc = acc && (((m_ctrl >> 7) & 1) == int'(hi));
      if (acc) chk(mem_addr == t[15:0], "R6 access addr", mem_addr, t);
      if (rd && !wr && acc) begin
         w = hi ? (m_buf >> 8) & 255 : m_buf & 255;
         chk(cpu_rdata == w[7:0], "R8 read byte", cpu_rdata, w);
      end
      if (wr && acc) begin
         chk(mem_we && mem_be == (hi ? 2'b10 : 2'b01), "R7 byte enable", mem_be, hi ? 2 : 1);
         if (hi) m_mem[t % MEMW][15:8] = d[7:0];
         else    m_mem[t % MEMW][7:0]  = d[7:0];
      end
      if (rd && wr) chk(!mem_re, "R11 write wins", mem_re, 0);
      if (wr && sel == 0) m_ctrl = d & 255;
      if (wr && sel == 1) m_addr = (m_addr & 'hFF00) | (d & 255);
      if (wr && sel == 2) m_addr = (m_addr & 'h00FF) | ((d & 255) << 8);
      if (inc && rd && !wr) m_buf = int'(m_mem[t % MEMW]);
      if (inc) m_addr = (m_addr + step_of(m_ctrl)) & 'hFFFF;
      @(posedge clk);
      #1;
      cpu_wr = 0; cpu_rd = 0;
   endtask

   task automatic set_addr(int a);
      op(1, 0, 1, a & 255);
      op(1, 0, 2, (a >> 8) & 255);
   endtask

   initial begin
      #800000;
      bad++; total++;
      $display("FAIL watchdog expired actual=0x0 expected=0x1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      for (int i = 0; i < MEMW; i++) begin vmem[i] = '0; m_mem[i] = '0; end
      repeat (3) @(posedge clk);
      #1 rst_n = 1;
      @(negedge clk);
      // R1: reset state
      cpu_sel = 3; #1 chk(cpu_rdata == 8'h00, "R1 low byte", cpu_rdata, 0);
      cpu_sel = 4; #1 chk(cpu_rdata == 8'h00, "R1 high byte", cpu_rdata, 0);
      chk(mem_addr == 16'h0000, "R1 address", mem_addr, 0);
      running = 1;

      // R3: step on high byte, word writes
      op(1, 0, 0, 'h80);
      set_addr('h0100);
      for (int i = 0; i < 4; i++) begin
         op(1, 0, 3, 'h10 + i);
         op(1, 0, 4, 'hA0 + i);
      end
      chk(mem_addr == 16'h0104, "R3 hi lane steps", mem_addr, 'h0104);

      // R3: step on low byte
      op(1, 0, 0, 'h00);
      set_addr('h0200);
      op(1, 0, 4, 'h5A);
      op(1, 0, 3, 'h3C);
      op(1, 0, 3, 'h3D);
      chk(mem_addr == 16'h0202, "R3 lo lane steps", mem_addr, 'h0202);

      // R4: steps 32 and 128 (both codes)
      op(1, 0, 0, 'h01); set_addr('h0300); op(1, 0, 3, 1);
      chk(mem_addr == 16'h0320, "R4 step 32", mem_addr, 'h0320);
      op(1, 0, 0, 'h02); op(1, 0, 3, 2);
      chk(mem_addr == 16'h03A0, "R4 step 128", mem_addr, 'h03A0);
      op(1, 0, 0, 'h03); op(1, 0, 3, 3);
      chk(mem_addr == 16'h0420, "R4 step 128 alt", mem_addr, 'h0420);

      // R6: mode 01 example
      op(1, 0, 0, 'h04); set_addr('h0003);
      chk(mem_addr == 16'h0018, "R6 remap 0x0003", mem_addr, 'h0018);
      op(1, 0, 3, 'hEE);
      op(1, 0, 0, 'h00);
      chk(mem_addr == 16'h0004, "R6 stored addr", mem_addr, 'h0004);

      // R5: modes 10 and 11 on a busy pattern
      op(1, 0, 0, 'h88); set_addr('hB6D5);
      chk(mem_addr == 16'(xlate('hB6D5, 2)), "R5 mode 10", mem_addr, xlate('hB6D5, 2));
      op(1, 0, 3, 'h21); op(1, 0, 4, 'h43);
      op(1, 0, 0, 'h8C); set_addr('h5A3F);
      chk(mem_addr == 16'(xlate('h5A3F, 3)), "R5 mode 11", mem_addr, xlate('h5A3F, 3));
      op(1, 0, 3, 'h65); op(1, 0, 4, 'h87);

      // R7: non-stepping write lands immediately
      op(1, 0, 0, 'h80); set_addr('h0500);
      op(1, 0, 3, 'h77);
      chk(vmem['h500] == 16'h0077, "R7 immediate write", vmem['h500], 'h77);

      // R8: stale first read, then data; R9 non-stepping read
      set_addr('h0100);
      op(0, 1, 4, 0);
      op(0, 1, 3, 0);
      op(0, 1, 3, 0);
      op(0, 1, 4, 0);
      op(0, 1, 4, 0);
      chk(mem_addr == 16'h0103, "R9 addr after reads", mem_addr, 'h0103);
      op(0, 0, 0, 0);
      // R11: both strobes
      op(1, 1, 4, 'h99);

      // R10: wrap by 1 and by 128
      op(1, 0, 0, 'h00); set_addr('hFFFF); op(1, 0, 3, 'h01);
      chk(mem_addr == 16'h0000, "R10 wrap by 1", mem_addr, 0);
      op(1, 0, 0, 'h02); set_addr('hFFC0); op(1, 0, 3, 'h02);
      chk(mem_addr == 16'h0040, "R10 wrap by 128", mem_addr, 'h40);

      // R8: low-lane read sequence under remap
      op(1, 0, 0, 'h04); set_addr('h0003);
      op(0, 1, 3, 0); op(0, 1, 3, 0); op(0, 1, 4, 0);

      running = 0;
      @(negedge clk);
      begin
         int mism = 0;
         for (int i = 0; i < MEMW; i++) if (vmem[i] !== m_mem[i]) mism++;
         chk(mism == 0, "R7 memory image", mism, 0);
      end
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule